// File: doc/BRIEF.md
# Stack and Data Pointer Unit

This unit keeps a byte-wide stack pointer and a 16-bit data pointer held as two byte halves, and turns stack commands into internal-RAM byte accesses. One command is given at a time on a valid/ready command port.

Single-byte push and pop each take one cycle. Subroutine call pushes a 16-bit return address, and return pops one. Pushing the data pointer stores both of its bytes. Each of these three takes two cycles, one per byte. The data pointer can be loaded one byte at a time and incremented as a whole 16-bit value. It has no decrement.

The stack grows upward. A push first advances the pointer, then writes. A pop reads, then steps the pointer back.

The RAM sits outside the unit. It must return read data combinationally, in the same cycle as the address. Writes happen at the clock edge that ends a cycle with `ram_we` high.

Back-pressure works as follows. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` drops for exactly one cycle, the second byte cycle of a two-byte command, and no command is taken then. Popped data and return addresses come back on a plain one-cycle `rsp_valid` strobe that has no back-pressure.

Top module: `spdp_unit`

## Requirements
- R1: After reset, `sp` is 07h, `dptr` is 0000h, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: Push (op 0) takes byte `cmd_data[7:0]`. In its acceptance cycle, `ram_we` is 1 and `ram_addr` is the old `sp` plus 1, so the first push after reset writes address 08h. `sp` then holds that new address.
- R3: Pop (op 1) reads `ram_addr` = `sp` in its acceptance cycle with `ram_we` 0, and `sp` then decreases by 1. In the next cycle, `rsp_valid` is 1 and `rsp_data` is {00h, byte read}. Commands other than pop and return leave `rsp_valid` at 0.
- R4: Call (op 2) with address `cmd_data[15:0]` writes the low byte at `sp`+1 in the acceptance cycle. It then writes the high byte at `sp`+2 in the following cycle. `sp` ends 2 higher.
- R5: Return (op 3) reads the high byte at `sp` in the acceptance cycle and the low byte at `sp`-1 in the next cycle, with `ram_we` 0 in both. `sp` ends 2 lower. In the cycle after the second read, `rsp_valid` is 1 and `rsp_data` is {high, low}.
- R6: Increment (op 4) adds 1 to the full 16-bit `dptr`. The carry passes from the low byte into the high byte, and FFFFh becomes 0000h.
- R7: Load-low (op 5) sets `dptr[7:0]` and load-high (op 6) sets `dptr[15:8]`, each from `cmd_data[7:0]`. The other half is unchanged.
- R8: Data-pointer push (op 7) writes the low byte of `dptr` at `sp`+1, then the high byte at `sp`+2. `sp` ends 2 higher.
- R9: `sp` wraps modulo 256 on both push and pop, and raises no error indication.
- R10: `cmd_ready` is 0 only in the second cycle of a call, return or data-pointer push. Exactly one command is carried out per acceptance.
- R11: Stack commands leave `dptr` unchanged. Data-pointer commands leave `sp` unchanged and keep `ram_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | Command code, 0 to 7 as listed in the requirements |
| cmd_data | input | 16 | Byte operand in [7:0]; call address in [15:0] |
| ram_addr | output | 8 | Internal-RAM byte address |
| ram_wdata | output | 8 | Byte to write |
| ram_we | output | 1 | Write strobe |
| ram_rdata | input | 8 | Combinational read data for `ram_addr` |
| rsp_valid | output | 1 | One-cycle strobe for popped data |
| rsp_data | output | 16 | Popped byte (zero-extended) or return address |
| sp | output | 8 | Current stack pointer |
| dptr | output | 16 | Current data pointer |

## Verification
The assertions assume three things about the environment:
- Every command is one of the eight codes.
- `ram_rdata` follows `ram_addr` within the same cycle.
- No command is offered while `cmd_ready` is low, so the second byte cycle always follows its own command.

The bench meets these by using a combinational RAM model. It drops `cmd_valid` right after each acceptance and waits out the second cycle before issuing the next command. It sweeps every stack address in both directions and every data-pointer value.

// File: rtl/spdp_pkg.sv
`timescale 1ns/1ps
package spdp_pkg;
  typedef enum logic [2:0] {
    OP_PUSH     = 3'd0,
    OP_POP      = 3'd1,
    OP_CALL     = 3'd2,
    OP_RET      = 3'd3,
    OP_DP_INC   = 3'd4,
    OP_DP_LD_LO = 3'd5,
    OP_DP_LD_HI = 3'd6,
    OP_DP_PUSH  = 3'd7
  } spdp_op_e;

  function automatic logic is_two_byte(spdp_op_e op);
    return (op == OP_CALL) || (op == OP_RET) || (op == OP_DP_PUSH);
  endfunction
endpackage

// File: rtl/spdp_stack.sv
`timescale 1ns/1ps
module spdp_stack
  import spdp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] SP_RESET = 'h07
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire,
  input  spdp_op_e              op,
  input  logic [2*BYTE_W-1:0]   cmd_data,
  input  logic [BYTE_W-1:0]     dp_lo,
  input  logic [BYTE_W-1:0]     dp_hi,
  input  logic [BYTE_W-1:0]     ram_rdata,
  output logic [ADDR_W-1:0]     ram_addr,
  output logic [BYTE_W-1:0]     ram_wdata,
  output logic                  ram_we,
  output logic                  busy,
  output logic                  rsp_valid,
  output logic [2*BYTE_W-1:0]   rsp_data,
  output logic [ADDR_W-1:0]     sp
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  logic              phase2;
  logic              p_read;
  logic [BYTE_W-1:0] p_byte;
  logic [ADDR_W-1:0] sp_nxt;
  logic [ADDR_W-1:0] sp_up;
  logic [ADDR_W-1:0] sp_dn;

  assign sp_up = sp + ONE;
  assign sp_dn = sp - ONE;
  assign busy  = phase2;

  always_comb begin
    ram_addr  = sp;
    ram_wdata = '0;
    ram_we    = 1'b0;
    sp_nxt    = sp;
    if (phase2) begin
      if (p_read) begin
        ram_addr = sp;
        sp_nxt   = sp_dn;
      end else begin
        ram_addr  = sp_up;
        ram_wdata = p_byte;
        ram_we    = 1'b1;
        sp_nxt    = sp_up;
      end
    end else if (fire) begin
      case (op)
        OP_PUSH, OP_CALL, OP_DP_PUSH: begin
          ram_addr  = sp_up;
          ram_wdata = (op == OP_DP_PUSH) ? dp_lo : cmd_data[BYTE_W-1:0];
          ram_we    = 1'b1;
          sp_nxt    = sp_up;
        end
        OP_POP, OP_RET: begin
          ram_addr = sp;
          sp_nxt   = sp_dn;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= SP_RESET;
      phase2    <= 1'b0;
      p_read    <= 1'b0;
      p_byte    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      sp        <= sp_nxt;
      rsp_valid <= 1'b0;
      if (phase2) begin
        phase2 <= 1'b0;
        if (p_read) begin
          rsp_valid <= 1'b1;
          rsp_data  <= {p_byte, ram_rdata};
        end
      end else if (fire) begin
        phase2 <= is_two_byte(op);
        p_read <= (op == OP_RET);
        case (op)
          OP_CALL:    p_byte <= cmd_data[2*BYTE_W-1:BYTE_W];
          OP_DP_PUSH: p_byte <= dp_hi;
          OP_RET:     p_byte <= ram_rdata;
          default:    p_byte <= p_byte;
        endcase
        if (op == OP_POP) begin
          rsp_valid <= 1'b1;
          rsp_data  <= {{BYTE_W{1'b0}}, ram_rdata};
        end
      end
    end
  end
endmodule

// File: rtl/spdp_dptr.sv
`timescale 1ns/1ps
module spdp_dptr
  import spdp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  spdp_op_e          op,
  input  logic [BYTE_W-1:0] ld_byte,
  output logic [BYTE_W-1:0] dp_lo,
  output logic [BYTE_W-1:0] dp_hi
);
  localparam int DP_W = 2 * BYTE_W;
  localparam logic [DP_W-1:0] ONE = 1;

  logic [DP_W-1:0] dp_sum;
  assign dp_sum = {dp_hi, dp_lo} + ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_lo <= '0;
      dp_hi <= '0;
    end else if (fire) begin
      case (op)
        OP_DP_INC:   {dp_hi, dp_lo} <= dp_sum;
        OP_DP_LD_LO: dp_lo <= ld_byte;
        OP_DP_LD_HI: dp_hi <= ld_byte;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spdp_unit.sv
`timescale 1ns/1ps
module spdp_unit
  import spdp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] SP_RESET = 'h07
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_op,
  input  logic [2*BYTE_W-1:0] cmd_data,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [BYTE_W-1:0]   ram_wdata,
  output logic                ram_we,
  input  logic [BYTE_W-1:0]   ram_rdata,
  output logic                rsp_valid,
  output logic [2*BYTE_W-1:0] rsp_data,
  output logic [ADDR_W-1:0]   sp,
  output logic [2*BYTE_W-1:0] dptr
);
  spdp_op_e          op;
  logic              fire;
  logic              busy;
  logic [BYTE_W-1:0] dp_lo;
  logic [BYTE_W-1:0] dp_hi;

  assign op        = spdp_op_e'(cmd_op);
  assign cmd_ready = !busy;
  assign fire      = cmd_valid && cmd_ready;
  assign dptr      = {dp_hi, dp_lo};

  spdp_stack #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .SP_RESET(SP_RESET)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .op        (op),
    .cmd_data  (cmd_data),
    .dp_lo     (dp_lo),
    .dp_hi     (dp_hi),
    .ram_rdata (ram_rdata),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .sp        (sp)
  );

  spdp_dptr #(.BYTE_W(BYTE_W)) u_dptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .op      (op),
    .ld_byte (cmd_data[BYTE_W-1:0]),
    .dp_lo   (dp_lo),
    .dp_hi   (dp_hi)
  );
endmodule

// File: rtl/spdp_unit_chk.sv
`timescale 1ns/1ps
module spdp_unit_chk
  import spdp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [2:0]          cmd_op,
  input logic [2*BYTE_W-1:0] cmd_data,
  input logic [ADDR_W-1:0]   ram_addr,
  input logic [BYTE_W-1:0]   ram_wdata,
  input logic                ram_we,
  input logic                rsp_valid,
  input logic [ADDR_W-1:0]   sp,
  input logic [2*BYTE_W-1:0] dptr
);
  logic go;
  logic dp_cmd;
  assign go     = cmd_valid && cmd_ready;
  assign dp_cmd = (cmd_op == OP_DP_INC) || (cmd_op == OP_DP_LD_LO) || (cmd_op == OP_DP_LD_HI);

  a_r2_write_sets_sp: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> sp == $past(ram_addr));

  a_r3_pop_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_POP) |=> (rsp_valid && sp == $past(sp) - 1'b1));

  a_r4_call_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_CALL) |=>
      (!cmd_ready && ram_we && ram_wdata == $past(cmd_data[2*BYTE_W-1:BYTE_W])));

  a_r5_ret_second_read: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_RET) |=> (!ram_we && ram_addr == $past(ram_addr) - 1'b1));

  a_r6_dptr_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_DP_INC) |=> dptr == $past(dptr) + 1'b1);

  a_r10_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> cmd_ready);

  a_r11_dptr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && dp_cmd) |=> $stable(dptr));

  a_r11_dp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dp_cmd) |-> !ram_we);
endmodule

bind spdp_unit spdp_unit_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/spdp_unit_test.sv
`timescale 1ns/1ps
module spdp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_data = 16'h0;
  logic [7:0]  ram_addr, ram_wdata, ram_rdata;
  logic        ram_we;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [7:0]  sp;
  logic [15:0] dptr;

  logic [7:0] mem [256];

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [7:0]  acc_addr, acc_wdata, ph_addr, ph_wdata;
  logic        acc_we, acc_ready, ph_we, ph_ready, e_rv;
  logic [15:0] e_rd;
  logic [7:0]  exp_sp;
  logic [15:0] exp_dp;

  always #2.5 clk = ~clk;

  spdp_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_rdata(ram_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sp(sp), .dptr(dptr)
  );

  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL R10 watchdog: cycles %0d expected below 190000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic step(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    #1;
    acc_addr = ram_addr; acc_wdata = ram_wdata; acc_we = ram_we; acc_ready = cmd_ready;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    ph_ready = 1'b1; ph_we = 1'b0; ph_addr = 8'h0; ph_wdata = 8'h0;
    if (op == 3'd2 || op == 3'd3 || op == 3'd7) begin
      ph_addr = ram_addr; ph_wdata = ram_wdata; ph_we = ram_we; ph_ready = cmd_ready;
      @(posedge clk); #1;
    end
    e_rv = rsp_valid; e_rd = rsp_data;
  endtask

  task automatic call_ret(input logic [15:0] a);
    step(3'd2, a);
    chk("R4 call low addr", {24'h0, acc_addr}, {24'h0, exp_sp + 8'd1});
    chk("R4 call low data", {24'h0, acc_wdata}, {24'h0, a[7:0]});
    chk("R4 call low we", {31'h0, acc_we}, 32'h1);
    chk("R10 call stall", {31'h0, ph_ready}, 32'h0);
    chk("R4 call high addr", {24'h0, ph_addr}, {24'h0, exp_sp + 8'd2});
    chk("R4 call high data", {24'h0, ph_wdata}, {24'h0, a[15:8]});
    chk("R4 call high we", {31'h0, ph_we}, 32'h1);
    exp_sp = exp_sp + 8'd2;
    chk("R10 call sp", {24'h0, sp}, {24'h0, exp_sp});
    step(3'd3, 16'h0);
    chk("R5 ret first addr", {24'h0, acc_addr}, {24'h0, exp_sp});
    chk("R5 ret second addr", {24'h0, ph_addr}, {24'h0, exp_sp - 8'd1});
    chk("R5 ret no write", {30'h0, acc_we, ph_we}, 32'h0);
    chk("R10 ret stall", {31'h0, ph_ready}, 32'h0);
    chk("R5 ret valid", {31'h0, e_rv}, 32'h1);
    chk("R5 ret addr", {16'h0, e_rd}, {16'h0, a});
    exp_sp = exp_sp - 8'd2;
    chk("R5 ret sp", {24'h0, sp}, {24'h0, exp_sp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp", {24'h0, sp}, 32'h07);
    chk("R1 dptr", {16'h0, dptr}, 32'h0);
    chk("R1 ready", {31'h0, cmd_ready}, 32'h1);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    exp_sp = 8'h07; exp_dp = 16'h0;

    for (int i = 0; i < 256; i++) begin
      step(3'd0, {8'h0, pat(i)});
      if (i == 0) chk("R2 first push at 08", {24'h0, acc_addr}, 32'h08);
      chk("R2 push addr", {24'h0, acc_addr}, {24'h0, exp_sp + 8'd1});
      chk("R2 push data", {24'h0, acc_wdata}, {24'h0, pat(i)});
      chk("R2 push we", {31'h0, acc_we}, 32'h1);
      exp_sp = exp_sp + 8'd1;
      if (exp_sp == 8'h00) chk("R9 push wrap", {24'h0, sp}, 32'h0);
      chk("R2 push sp", {24'h0, sp}, {24'h0, exp_sp});
      chk("R3 no rsp on push", {31'h0, e_rv}, 32'h0);
      chk("R11 dptr after push", {16'h0, dptr}, {16'h0, exp_dp});
    end

    for (int k = 0; k < 256; k++) begin
      step(3'd1, 16'h0);
      chk("R3 pop addr", {24'h0, acc_addr}, {24'h0, exp_sp});
      chk("R3 pop no write", {31'h0, acc_we}, 32'h0);
      exp_sp = exp_sp - 8'd1;
      if (exp_sp == 8'hFF) chk("R9 pop wrap", {24'h0, sp}, 32'hFF);
      chk("R3 pop sp", {24'h0, sp}, {24'h0, exp_sp});
      chk("R3 pop valid", {31'h0, e_rv}, 32'h1);
      chk("R3 pop data", {16'h0, e_rd}, {24'h0, pat(255 - k)});
    end

    for (int k = 0; k < 9; k++) begin
      step(3'd1, 16'h0);
      exp_sp = exp_sp - 8'd1;
    end
    chk("R9 sp below zero", {24'h0, sp}, 32'hFE);

    for (int k = 0; k < 16; k++) begin
      logic [15:0] a;
      a = (16'(k) * 16'h1111) ^ 16'h0F3C;
      call_ret(a);
      step(3'd0, {8'h0, 8'(k)});
      exp_sp = exp_sp + 8'd1;
    end

    step(3'd2, 16'hBEEF); exp_sp = exp_sp + 8'd2;
    step(3'd2, 16'h1357); exp_sp = exp_sp + 8'd2;
    step(3'd2, 16'hA0C1); exp_sp = exp_sp + 8'd2;
    step(3'd3, 16'h0); chk("R5 nested 3", {16'h0, e_rd}, 32'hA0C1);
    step(3'd3, 16'h0); chk("R5 nested 2", {16'h0, e_rd}, 32'h1357);
    step(3'd3, 16'h0); chk("R5 nested 1", {16'h0, e_rd}, 32'hBEEF);
    exp_sp = exp_sp - 8'd6;
    chk("R5 nested sp", {24'h0, sp}, {24'h0, exp_sp});

    step(3'd5, 16'hFF34); exp_dp = 16'h0034;
    chk("R7 load low", {16'h0, dptr}, {16'h0, exp_dp});
    chk("R11 load no write", {31'h0, acc_we}, 32'h0);
    chk("R11 load sp", {24'h0, sp}, {24'h0, exp_sp});
    chk("R3 no rsp on load", {31'h0, e_rv}, 32'h0);
    step(3'd6, 16'h0012); exp_dp = 16'h1234;
    chk("R7 load high", {16'h0, dptr}, {16'h0, exp_dp});
    step(3'd5, 16'h00CD); exp_dp = 16'h12CD;
    chk("R7 low keeps high", {16'h0, dptr}, {16'h0, exp_dp});

    step(3'd7, 16'h0);
    chk("R8 low first addr", {24'h0, acc_addr}, {24'h0, exp_sp + 8'd1});
    chk("R8 low first data", {24'h0, acc_wdata}, 32'hCD);
    chk("R8 high addr", {24'h0, ph_addr}, {24'h0, exp_sp + 8'd2});
    chk("R8 high data", {24'h0, ph_wdata}, 32'h12);
    chk("R10 dptr push stall", {31'h0, ph_ready}, 32'h0);
    exp_sp = exp_sp + 8'd2;
    chk("R8 sp", {24'h0, sp}, {24'h0, exp_sp});
    step(3'd1, 16'h0); chk("R8 pop high", {16'h0, e_rd}, 32'h0012);
    step(3'd1, 16'h0); chk("R8 pop low", {16'h0, e_rd}, 32'h00CD);
    exp_sp = exp_sp - 8'd2;
    chk("R11 stack ops keep dptr", {16'h0, dptr}, {16'h0, exp_dp});

    step(3'd5, 16'h0); step(3'd6, 16'h0); exp_dp = 16'h0;
    for (int i = 0; i < 65536; i++) begin
      step(3'd4, 16'h0);
      exp_dp = exp_dp + 16'd1;
      chk("R6 increment", {16'h0, dptr}, {16'h0, exp_dp});
      if (acc_we !== 1'b0 || sp !== exp_sp)
        chk("R11 inc quiet", {23'h0, acc_we, sp}, {24'h0, exp_sp});
    end
    chk("R6 wrap to zero", {16'h0, dptr}, 32'h0);
    chk("R11 sp after incs", {24'h0, sp}, {24'h0, exp_sp});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule